// File: doc/BRIEF.md
# Greedy Sparse Recovery Sequencer

This block is the control engine of a greedy sparse-reconstruction accelerator. It holds no arithmetic. It starts four external arithmetic units in a fixed schedule and waits for each one to finish. The units are atom search, orthogonalization of the newly chosen column against the earlier ones, residual update, and a final least-squares solve. Every loop pass runs search, then orthogonalization, then residual update. The least-squares solve is issued only once, after the loop has ended, and it works only on the columns that were selected.

Each run begins with a start request. The request captures the target sparsity and the noise threshold, and it clears the iteration count, the selected-index file and the cycle counter. While the loop runs, each search result is stored in the index file at the slot given by the current pass number. After every residual update, the sequencer compares the residual energy reported by the update unit against the threshold and decides whether to search again or to finish. A cycle counter shows how long the whole run took, so the total can be checked against the sum of the stage latencies. A done flag remains high until the next run starts.

Top module: `sparse_recovery_seq`

## Requirements
- R1: A start request accepted while idle or finished clears the pass count, the cycle count and every index entry. On the next cycle it raises the search start pulse, and busy goes high.
- R2: Each pass runs search, then orthogonalization, then residual update. Each unit gets a one-cycle start pulse, registered at the edge where the previous unit's done is sampled. No two start pulses are ever high together.
- R3: The index returned by a search is stored in entry N, where N is the number of passes already completed, counting from zero. The read port returns that entry, and an entry not written since the last start reads as zero.
- R4: When the residual update finishes, the pass count increments. Looping continues only if the new count is below the target and the residual energy is strictly greater than the threshold, using an unsigned comparison. An energy equal to the threshold ends the loop.
- R5: When the residual energy stays above the threshold, exactly the target number of passes run.
- R6: After the loop ends, the solve start pulse is issued exactly once, and it is followed by nothing else.
- R7: The edge that samples the solve done sets done and clears busy. Done stays high, and busy low, until the next accepted start.
- R8: A start request received while busy has no effect on the schedule, the counts or the stored indices.
- R9: The cycle counter counts the clock edges at which the sequencer is busy. With a unit that raises done L cycles after it samples its start pulse, each stage adds L+1. The counter holds its value while done is high.
- R10: The target sparsity is captured at start. A value of 0 acts as 1, and a value above K_MAX acts as K_MAX. The threshold is also captured at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request |
| target_k_i | input | KW | Requested number of passes (sparsity) |
| noise_thr_i | input | EN_W | Residual energy threshold |
| res_energy_i | input | EN_W | Residual energy, valid with resid_done_i |
| search_start_o | output | 1 | Atom search start pulse |
| search_done_i | input | 1 | Atom search done pulse |
| search_idx_i | input | IDX_W | Index chosen by atom search, valid with search_done_i |
| ortho_start_o | output | 1 | Orthogonalization start pulse |
| ortho_done_i | input | 1 | Orthogonalization done pulse |
| resid_start_o | output | 1 | Residual update start pulse |
| resid_done_i | input | 1 | Residual update done pulse |
| solve_start_o | output | 1 | Least-squares solve start pulse |
| solve_done_i | input | 1 | Least-squares solve done pulse |
| idx_rd_addr_i | input | KW | Index file read address |
| idx_rd_data_o | output | IDX_W | Index file read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished; held until the next start |
| iter_count_o | output | KW | Passes completed |
| cycle_count_o | output | CYC_W | Busy cycles of the current or last run |

## Verification
Randomized runs vary the target sparsity, the threshold, the per-unit latencies and the sequence of residual energies. Because the energies drop below the threshold at random points, these runs separate early termination on the energy from termination on the pass limit. The pass limit alone is exercised by a directed run in which the energy always stays above the threshold, using the large reference latencies. Another directed run makes the energy exactly equal to the threshold, which separates a strict comparison from a non-strict one. Targets of 0 and above K_MAX test the clamping. Start requests injected in the middle of a run must leave every total unchanged, and the exact cycle count ties each stage's latency to its L+1 contribution.

// File: rtl/sparse_seq_pkg.sv
package sparse_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SEARCH = 3'd1,
        ST_ORTHO  = 3'd2,
        ST_RESID  = 3'd3,
        ST_SOLVE  = 3'd4,
        ST_DONE   = 3'd5
    } seq_state_e;

    function automatic logic state_running(seq_state_e s);
        return (s == ST_SEARCH) || (s == ST_ORTHO) ||
               (s == ST_RESID)  || (s == ST_SOLVE);
    endfunction

endpackage

// File: rtl/sparse_seq_ctrl.sv
module sparse_seq_ctrl
    import sparse_seq_pkg::*;
#(
    parameter int K_MAX = 16,
    parameter int EN_W  = 32,
    localparam int KW   = $clog2(K_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [KW-1:0]   target_k_i,
    input  logic [EN_W-1:0] noise_thr_i,
    input  logic [EN_W-1:0] res_energy_i,
    input  logic            search_done_i,
    input  logic            ortho_done_i,
    input  logic            resid_done_i,
    input  logic            solve_done_i,
    output logic            search_start_o,
    output logic            ortho_start_o,
    output logic            resid_start_o,
    output logic            solve_start_o,
    output logic            accept_o,
    output logic            idx_we_o,
    output logic            running_o,
    output logic            done_o,
    output logic [KW-1:0]   iter_o
);

    localparam logic [KW-1:0] K_LIMIT = KW'(K_MAX);
    localparam logic [KW-1:0] ONE     = KW'(1);

    typedef struct packed {
        seq_state_e      state;
        logic [KW-1:0]   k;
        logic [EN_W-1:0] thr;
        logic [KW-1:0]   iter;
        logic            srch_go;
        logic            orth_go;
        logic            res_go;
        logic            sol_go;
        logic            fin;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  accept_d, we_d;
    logic [KW-1:0] k_clamped;
    logic [KW-1:0] iter_next;

    always_comb begin
        if (target_k_i == '0) begin
            k_clamped = ONE;
        end else if (target_k_i > K_LIMIT) begin
            k_clamped = K_LIMIT;
        end else begin
            k_clamped = target_k_i;
        end
    end

    assign iter_next = ctrl_q.iter + ONE;

    always_comb begin
        ctrl_d         = ctrl_q;
        ctrl_d.srch_go = 1'b0;
        ctrl_d.orth_go = 1'b0;
        ctrl_d.res_go  = 1'b0;
        ctrl_d.sol_go  = 1'b0;
        accept_d       = 1'b0;
        we_d           = 1'b0;
        case (ctrl_q.state)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    accept_d       = 1'b1;
                    ctrl_d.k       = k_clamped;
                    ctrl_d.thr     = noise_thr_i;
                    ctrl_d.iter    = '0;
                    ctrl_d.fin     = 1'b0;
                    ctrl_d.state   = ST_SEARCH;
                    ctrl_d.srch_go = 1'b1;
                end
            end
            ST_SEARCH: begin
                if (search_done_i) begin
                    we_d           = 1'b1;
                    ctrl_d.state   = ST_ORTHO;
                    ctrl_d.orth_go = 1'b1;
                end
            end
            ST_ORTHO: begin
                if (ortho_done_i) begin
                    ctrl_d.state  = ST_RESID;
                    ctrl_d.res_go = 1'b1;
                end
            end
            ST_RESID: begin
                if (resid_done_i) begin
                    ctrl_d.iter = iter_next;
                    if ((iter_next < ctrl_q.k) && (res_energy_i > ctrl_q.thr)) begin
                        ctrl_d.state   = ST_SEARCH;
                        ctrl_d.srch_go = 1'b1;
                    end else begin
                        ctrl_d.state  = ST_SOLVE;
                        ctrl_d.sol_go = 1'b1;
                    end
                end
            end
            ST_SOLVE: begin
                if (solve_done_i) begin
                    ctrl_d.state = ST_DONE;
                    ctrl_d.fin   = 1'b1;
                end
            end
            default: begin
                ctrl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, default: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign search_start_o = ctrl_q.srch_go;
    assign ortho_start_o  = ctrl_q.orth_go;
    assign resid_start_o  = ctrl_q.res_go;
    assign solve_start_o  = ctrl_q.sol_go;
    assign accept_o       = accept_d;
    assign idx_we_o       = we_d;
    assign running_o      = state_running(ctrl_q.state);
    assign done_o         = ctrl_q.fin;
    assign iter_o         = ctrl_q.iter;

endmodule

// File: rtl/sparse_idx_file.sv
module sparse_idx_file #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 11,
    localparam int KW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             we_i,
    input  logic [KW-1:0]    waddr_i,
    input  logic [IDX_W-1:0] wdata_i,
    input  logic [KW-1:0]    raddr_i,
    output logic [IDX_W-1:0] rdata_o
);

    logic [IDX_W-1:0] entry_d [DEPTH];
    logic [IDX_W-1:0] entry_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_comb begin
            entry_d[g] = entry_q[g];
            if (clr_i) begin
                entry_d[g] = '0;
            end else if (we_i && (waddr_i == KW'(g))) begin
                entry_d[g] = wdata_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[g] <= '0;
            end else begin
                entry_q[g] <= entry_d[g];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr_i == KW'(i)) begin
                rdata_o = entry_q[i];
            end
        end
    end

endmodule

// File: rtl/sparse_cycle_ctr.sv
module sparse_cycle_ctr #(
    parameter int CYC_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    output logic [CYC_W-1:0] count_o
);

    localparam logic [CYC_W-1:0] CNT_MAX = '1;

    logic [CYC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + CYC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/sparse_recovery_seq.sv
module sparse_recovery_seq #(
    parameter int K_MAX = 16,
    parameter int IDX_W = 11,
    parameter int EN_W  = 32,
    parameter int CYC_W = 20,
    localparam int KW   = $clog2(K_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [KW-1:0]    target_k_i,
    input  logic [EN_W-1:0]  noise_thr_i,
    input  logic [EN_W-1:0]  res_energy_i,
    output logic             search_start_o,
    input  logic             search_done_i,
    input  logic [IDX_W-1:0] search_idx_i,
    output logic             ortho_start_o,
    input  logic             ortho_done_i,
    output logic             resid_start_o,
    input  logic             resid_done_i,
    output logic             solve_start_o,
    input  logic             solve_done_i,
    input  logic [KW-1:0]    idx_rd_addr_i,
    output logic [IDX_W-1:0] idx_rd_data_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [KW-1:0]    iter_count_o,
    output logic [CYC_W-1:0] cycle_count_o
);

    logic          accept;
    logic          idx_we;
    logic          running;
    logic [KW-1:0] iter;

    sparse_seq_ctrl #(
        .K_MAX (K_MAX),
        .EN_W  (EN_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .target_k_i     (target_k_i),
        .noise_thr_i    (noise_thr_i),
        .res_energy_i   (res_energy_i),
        .search_done_i  (search_done_i),
        .ortho_done_i   (ortho_done_i),
        .resid_done_i   (resid_done_i),
        .solve_done_i   (solve_done_i),
        .search_start_o (search_start_o),
        .ortho_start_o  (ortho_start_o),
        .resid_start_o  (resid_start_o),
        .solve_start_o  (solve_start_o),
        .accept_o       (accept),
        .idx_we_o       (idx_we),
        .running_o      (running),
        .done_o         (done_o),
        .iter_o         (iter)
    );

    sparse_idx_file #(
        .DEPTH (K_MAX),
        .IDX_W (IDX_W)
    ) u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept),
        .we_i    (idx_we),
        .waddr_i (iter),
        .wdata_i (search_idx_i),
        .raddr_i (idx_rd_addr_i),
        .rdata_o (idx_rd_data_o)
    );

    sparse_cycle_ctr #(
        .CYC_W (CYC_W)
    ) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (accept),
        .en_i    (running),
        .count_o (cycle_count_o)
    );

    assign busy_o       = running;
    assign iter_count_o = iter;

endmodule

// File: rtl/sparse_recovery_seq_chk.sv
module sparse_recovery_seq_chk #(
    parameter int K_MAX = 16,
    parameter int CYC_W = 20,
    localparam int KW   = $clog2(K_MAX + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             search_start_o,
    input logic             ortho_start_o,
    input logic             resid_start_o,
    input logic             solve_start_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [KW-1:0]    iter_count_o,
    input logic [CYC_W-1:0] cycle_count_o
);

    p_single_stage_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({search_start_o, ortho_start_o, resid_start_o, solve_start_o}));

    p_search_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        search_start_o |=> !search_start_o);

    p_solve_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        solve_start_o |=> !solve_start_o && !search_start_o);

    p_iter_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        iter_count_o <= KW'(K_MAX));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o);

    p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> cycle_count_o != '0);

    p_cycle_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> $stable(cycle_count_o));

endmodule

bind sparse_recovery_seq sparse_recovery_seq_chk #(
    .K_MAX (K_MAX),
    .CYC_W (CYC_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .search_start_o (search_start_o),
    .ortho_start_o  (ortho_start_o),
    .resid_start_o  (resid_start_o),
    .solve_start_o  (solve_start_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .iter_count_o   (iter_count_o),
    .cycle_count_o  (cycle_count_o)
);

// File: tb/sparse_recovery_seq_bench.sv
module sparse_unit_stub (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] lat,
    input  logic        go,
    output logic        done
);
    logic [15:0] cnt;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (go) begin
            if (lat <= 16'd1) begin
                done <= 1'b1;
                cnt  <= '0;
            end else begin
                done <= 1'b0;
                cnt  <= lat - 16'd1;
            end
        end else if (cnt != '0) begin
            cnt  <= cnt - 16'd1;
            done <= (cnt == 16'd1);
        end else begin
            done <= 1'b0;
        end
    end
endmodule

module sparse_recovery_seq_bench;
    localparam int K_MAX  = 16;
    localparam int IDX_W  = 11;
    localparam int EN_W   = 32;
    localparam int CYC_W  = 20;
    localparam int KW     = $clog2(K_MAX + 1);
    localparam int CLK_NS = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [KW-1:0]    target_k_i = '0;
    logic [EN_W-1:0]  noise_thr_i = '0;
    logic [EN_W-1:0]  res_energy_i;
    logic             search_start_o, ortho_start_o, resid_start_o, solve_start_o;
    logic             search_done_i, ortho_done_i, resid_done_i, solve_done_i;
    logic [IDX_W-1:0] search_idx_i;
    logic [KW-1:0]    idx_rd_addr_i = '0;
    logic [IDX_W-1:0] idx_rd_data_o;
    logic             busy_o, done_o;
    logic [KW-1:0]    iter_count_o;
    logic [CYC_W-1:0] cycle_count_o;

    logic [15:0] lat_s = 16'd1, lat_o = 16'd1, lat_r = 16'd1, lat_v = 16'd1;
    logic [EN_W-1:0]  energy_arr [32];
    logic [IDX_W-1:0] idx_arr    [32];
    int spass = 0;
    int rpass = 0;

    int n_checks = 0;
    int n_fail   = 0;
    int solve_cnt = 0;
    int order_err = 0;
    int busy_cyc  = 0;
    int exp_stage = 0;

    always #(CLK_NS / 2) clk = ~clk;

    sparse_recovery_seq #(
        .K_MAX (K_MAX), .IDX_W (IDX_W), .EN_W (EN_W), .CYC_W (CYC_W)
    ) u_sparse_recovery_seq (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .target_k_i (target_k_i), .noise_thr_i (noise_thr_i),
        .res_energy_i (res_energy_i),
        .search_start_o (search_start_o), .search_done_i (search_done_i),
        .search_idx_i (search_idx_i),
        .ortho_start_o (ortho_start_o), .ortho_done_i (ortho_done_i),
        .resid_start_o (resid_start_o), .resid_done_i (resid_done_i),
        .solve_start_o (solve_start_o), .solve_done_i (solve_done_i),
        .idx_rd_addr_i (idx_rd_addr_i), .idx_rd_data_o (idx_rd_data_o),
        .busy_o (busy_o), .done_o (done_o),
        .iter_count_o (iter_count_o), .cycle_count_o (cycle_count_o)
    );

    sparse_unit_stub u_st_s (.clk(clk), .rst_n(rst_n), .lat(lat_s), .go(search_start_o), .done(search_done_i));
    sparse_unit_stub u_st_o (.clk(clk), .rst_n(rst_n), .lat(lat_o), .go(ortho_start_o),  .done(ortho_done_i));
    sparse_unit_stub u_st_r (.clk(clk), .rst_n(rst_n), .lat(lat_r), .go(resid_start_o),  .done(resid_done_i));
    sparse_unit_stub u_st_v (.clk(clk), .rst_n(rst_n), .lat(lat_v), .go(solve_start_o),  .done(solve_done_i));

    // Pass counters for the data the stubs return with their done pulses.
    always @(posedge clk) begin
        if (start_i && !busy_o) begin
            spass <= 0;
            rpass <= 0;
        end else begin
            if (search_start_o) spass <= spass + 1;
            if (resid_start_o)  rpass <= rpass + 1;
        end
    end
    assign search_idx_i = idx_arr[(spass > 0) ? ((spass - 1) % 32) : 0];
    assign res_energy_i = energy_arr[(rpass > 0) ? ((rpass - 1) % 32) : 0];

    // Order monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (busy_o) busy_cyc <= busy_cyc + 1;
        if (search_start_o) begin
            if (exp_stage != 0) order_err <= order_err + 1;
            exp_stage <= 1;
        end
        if (ortho_start_o) begin
            if (exp_stage != 1) order_err <= order_err + 1;
            exp_stage <= 2;
        end
        if (resid_start_o) begin
            if (exp_stage != 2) order_err <= order_err + 1;
            exp_stage <= 0;
        end
        if (solve_start_o) begin
            if (exp_stage != 0) order_err <= order_err + 1;
            solve_cnt <= solve_cnt + 1;
            exp_stage <= 3;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp_k(input int k);
        if (k == 0) return 1;
        if (k > K_MAX) return K_MAX;
        return k;
    endfunction

    function automatic int passes(input int k, input longint thr);
        int p = 0;
        int keff = clamp_k(k);
        forever begin
            p++;
            if (!((p < keff) && (longint'(energy_arr[p - 1]) > thr))) return p;
        end
    endfunction

    task automatic run_case(input int k, input longint thr, input int ls, input int lo,
                            input int lr, input int lv, input bit poke);
        int p;
        longint exp_cyc;
        logic [CYC_W-1:0] held;
        p = passes(k, thr);
        exp_cyc = longint'(p) * (ls + lo + lr + 3) + lv + 1;
        @(negedge clk);
        lat_s = 16'(ls); lat_o = 16'(lo); lat_r = 16'(lr); lat_v = 16'(lv);
        target_k_i  = KW'(k);
        noise_thr_i = EN_W'(thr);
        solve_cnt = 0; order_err = 0; busy_cyc = 0; exp_stage = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1 busy after start", busy_o, 1);
        chk("R1 search start pulse", search_start_o, 1);
        if (poke) begin
            repeat (2) @(negedge clk);
            if (busy_o) begin
                start_i = 1'b1;
                target_k_i = KW'(1);
                @(negedge clk);
                start_i = 1'b0;
            end
        end
        while (!done_o) @(negedge clk);
        chk("R4 R5 R10 pass count", iter_count_o, p);
        chk("R9 cycle count", cycle_count_o, exp_cyc);
        chk("R9 busy cycles", busy_cyc, exp_cyc);
        chk("R6 solve issued once", solve_cnt, 1);
        chk("R2 stage order", order_err, 0);
        chk("R7 busy low at done", busy_o, 0);
        for (int i = 0; i < p; i++) begin
            idx_rd_addr_i = KW'(i);
            #1;
            chk("R3 stored index", idx_rd_data_o, idx_arr[i]);
        end
        if (p < K_MAX) begin
            idx_rd_addr_i = KW'(p);
            #1;
            chk("R3 unwritten entry zero", idx_rd_data_o, 0);
        end
        held = cycle_count_o;
        repeat (4) @(negedge clk);
        chk("R7 done held", done_o, 1);
        chk("R9 count frozen", cycle_count_o, held);
    endtask

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 32; i++) begin
            energy_arr[i] = 32'd1000;
            idx_arr[i]    = IDX_W'(i * 37 + 5);
        end
        repeat (3) @(negedge clk);
        chk("R1 reset busy", busy_o, 0);
        chk("R7 reset done", done_o, 0);
        chk("R9 reset cycle count", cycle_count_o, 0);
        chk("R1 reset pass count", iter_count_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Reference latencies, energy always above: pass limit ends the loop (R5).
        run_case(12, 100, 4245, 600, 453, 1080, 1'b0);

        // Energy equal to threshold in pass 2 ends the loop (R4).
        energy_arr[0] = 32'd500; energy_arr[1] = 32'd200; energy_arr[2] = 32'd900;
        run_case(10, 200, 3, 2, 4, 5, 1'b0);

        // Target clamping (R10).
        for (int i = 0; i < 32; i++) energy_arr[i] = 32'hFFFF_0000;
        run_case(0, 10, 2, 1, 1, 3, 1'b0);
        run_case(20, 10, 1, 1, 1, 1, 1'b0);

        // Start while busy is ignored (R8).
        run_case(5, 10, 6, 2, 3, 4, 1'b1);

        // Threshold compare is unsigned (R4): a large energy with top bit set beats a small one.
        energy_arr[0] = 32'h8000_0000; energy_arr[1] = 32'd3;
        run_case(6, 32'h7FFF_FFFF, 2, 2, 2, 2, 1'b0);

        // Constrained random runs.
        for (int r = 0; r < 24; r++) begin
            longint thr;
            thr = longint'($urandom_range(100, 200));
            for (int i = 0; i < 32; i++) begin
                energy_arr[i] = EN_W'($urandom_range(120, 400) - (i * 8));
                idx_arr[i]    = IDX_W'($urandom);
            end
            run_case(int'($urandom_range(0, K_MAX + 2)), thr,
                     int'($urandom_range(1, 12)), int'($urandom_range(1, 12)),
                     int'($urandom_range(1, 12)), int'($urandom_range(1, 12)),
                     1'($urandom_range(0, 1)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R7 watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule